// File: doc/BRIEF.md
# Polled Device Port Controller

This block sits between a host register bus and a simple byte-wide device. The host sees four registers at fixed word offsets: an incoming-byte register, an outgoing-byte register, a read-only status word and a control word. To move one byte, the host first waits until the status busy flag reads 0. For an output transfer it then loads the outgoing byte. Last, it writes the control word with the command-ready bit set and the direction bit chosen.

The controller notices the pending command and raises busy. It then holds a request to the device until the device acknowledges. When the transfer ends, the controller clears command-ready, busy and the error flag in one step and sets the done flag. For an input transfer it also captures the device byte and flags it as waiting.

If the device stays silent for too long, the controller abandons the transfer. In that case it sets the error flag, which stays visible until the host issues another command. The host finds out about every outcome only by polling the status word.

Top module: `polled_port_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every register and flag, idles the sequencer and drops the device request; after reset every register reads 0.
- R2: Register offsets: 0x0 incoming byte (read-only), 0x4 outgoing byte (read/write), 0x8 status (bit0 busy, bit1 byte-waiting, bit2 error, bit3 done), 0xC control (bit0 command-ready, bit1 direction where 1 means output, bit2 mode). Reads of any other offset return 0.
- R3: A control write with bit0 = 1 while no command is pending records direction and mode, sets command-ready, and clears error and done. Busy and the device request rise on the following clock edge. The device direction output equals the direction bit, and the device data output equals the outgoing byte.
- R4: An acknowledge sampled while busy ends the transfer at that edge. Busy, command-ready and error go to 0, and done goes to 1.
- R5: On a completed input transfer, the device byte is latched into the incoming-byte register and byte-waiting is set. A host read of offset 0x0 clears byte-waiting.
- R6: A completed output transfer leaves the incoming-byte register and byte-waiting unchanged.
- R7: If no acknowledge arrives within TIMEOUT busy cycles, the transfer is aborted. Busy and command-ready clear, error and done set, and nothing is latched. An acknowledge arriving after the abort has no effect.
- R8: The error flag stays set through any number of status reads and is cleared only by issuing the next command.
- R9: While command-ready is 1, writes to the control and outgoing-byte registers are ignored.
- R10: The device mode output follows the control mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_rd_en | input | 1 | Host register read strobe |
| reg_addr | input | 4 | Host register byte offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from addr |
| dev_req | output | 1 | Transfer request to device, high while busy |
| dev_we | output | 1 | 1 for output transfer, 0 for input |
| dev_wdata | output | 8 | Byte offered to device |
| dev_mode | output | 1 | Device mode select |
| dev_ack | input | 1 | Device acknowledge |
| dev_rdata | input | 8 | Byte returned by device, sampled with ack |

## Verification
A wrong sequencer state shows up at the ports within one cycle of the command write or of the acknowledge. A stuck or missing busy flag shows on dev_req and in the status word, and a missed completion leaves done low when it is read back right after the acknowledge edge. A wrong timeout count is exposed by sweeping the acknowledge delay across the TIMEOUT boundary. Just below the boundary, error must stay 0 and input data must be latched; at the boundary and beyond, error must be 1 and no byte may be latched. Corrupted lock or flag state shows on the next readback of the control, status or incoming-byte registers.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NUM_REGS = 4;

    localparam int IDX_DIN  = 0;
    localparam int IDX_DOUT = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_CTRL = 3;

    localparam int ST_BUSY  = 0;
    localparam int ST_AVAIL = 1;
    localparam int ST_ERR   = 2;
    localparam int ST_DONE  = 3;

    localparam int CT_CMD  = 0;
    localparam int CT_WNR  = 1;
    localparam int CT_MODE = 2;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_XFER = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] dout;
        logic              cmd;
        logic              wnr;
        logic              mode;
        logic              avail;
        logic              err;
        logic              done;
    } port_regs_t;
endpackage

// File: rtl/pp_addr_decode.sv
module pp_addr_decode
    import pp_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [NUM_REGS-1:0] hit,
    output logic                wr_dout,
    output logic                wr_ctrl,
    output logic                rd_din
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i] = (addr == ADDR_W'(i * 4));
    end

    always_comb begin
        wr_dout = wr_en & hit[IDX_DOUT];
        wr_ctrl = wr_en & hit[IDX_CTRL];
        rd_din  = rd_en & hit[IDX_DIN];
    end
endmodule

// File: rtl/pp_xfer_seq.sv
module pp_xfer_seq
    import pp_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_pending,
    input  logic dev_ack,
    output logic busy,
    output logic fin_ok,
    output logic fin_abort
);
    localparam int TMR_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [TMR_W-1:0] timer;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        fin_ok    = 1'b0;
        fin_abort = 1'b0;
        case (seq_q.state)
            SEQ_IDLE: begin
                if (cmd_pending) begin
                    seq_d.state = SEQ_XFER;
                    seq_d.timer = '0;
                end
            end
            SEQ_XFER: begin
                if (dev_ack) begin
                    fin_ok      = 1'b1;
                    seq_d.state = SEQ_IDLE;
                end else if (seq_q.timer == TMR_LAST) begin
                    fin_abort   = 1'b1;
                    seq_d.state = SEQ_IDLE;
                end else begin
                    seq_d.timer = seq_q.timer + 1'b1;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{state: SEQ_IDLE, timer: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.state == SEQ_XFER);
endmodule

// File: rtl/polled_port_ctrl.sv
module polled_port_ctrl
    import pp_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dev_req,
    output logic              dev_we,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_mode,
    input  logic              dev_ack,
    input  logic [DATA_W-1:0] dev_rdata
);
    logic [NUM_REGS-1:0] hit;
    logic wr_dout, wr_ctrl, rd_din;
    logic busy, fin_ok, fin_abort;
    port_regs_t regs_d, regs_q;

    pp_addr_decode u_dec (
        .addr    (reg_addr),
        .wr_en   (reg_wr_en),
        .rd_en   (reg_rd_en),
        .hit     (hit),
        .wr_dout (wr_dout),
        .wr_ctrl (wr_ctrl),
        .rd_din  (rd_din)
    );

    pp_xfer_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_pending (regs_q.cmd),
        .dev_ack     (dev_ack),
        .busy        (busy),
        .fin_ok      (fin_ok),
        .fin_abort   (fin_abort)
    );

    always_comb begin
        regs_d = regs_q;
        if (!regs_q.cmd && wr_ctrl) begin
            regs_d.wnr  = reg_wdata[CT_WNR];
            regs_d.mode = reg_wdata[CT_MODE];
            if (reg_wdata[CT_CMD]) begin
                regs_d.cmd  = 1'b1;
                regs_d.err  = 1'b0;
                regs_d.done = 1'b0;
            end
        end
        if (!regs_q.cmd && wr_dout) begin
            regs_d.dout = reg_wdata;
        end
        if (rd_din) begin
            regs_d.avail = 1'b0;
        end
        if (fin_ok) begin
            regs_d.cmd  = 1'b0;
            regs_d.err  = 1'b0;
            regs_d.done = 1'b1;
            if (!regs_q.wnr) begin
                regs_d.din   = dev_rdata;
                regs_d.avail = 1'b1;
            end
        end
        if (fin_abort) begin
            regs_d.cmd  = 1'b0;
            regs_d.err  = 1'b1;
            regs_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (1'b1)
            hit[IDX_DIN]:  reg_rdata = regs_q.din;
            hit[IDX_DOUT]: reg_rdata = regs_q.dout;
            hit[IDX_STAT]: begin
                reg_rdata[ST_BUSY]  = busy;
                reg_rdata[ST_AVAIL] = regs_q.avail;
                reg_rdata[ST_ERR]   = regs_q.err;
                reg_rdata[ST_DONE]  = regs_q.done;
            end
            hit[IDX_CTRL]: begin
                reg_rdata[CT_CMD]  = regs_q.cmd;
                reg_rdata[CT_WNR]  = regs_q.wnr;
                reg_rdata[CT_MODE] = regs_q.mode;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign dev_req   = busy;
    assign dev_we    = regs_q.wnr;
    assign dev_wdata = regs_q.dout;
    assign dev_mode  = regs_q.mode;
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
    parameter int TIMEOUT = 16
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic cmd,
    input logic wnr,
    input logic mode,
    input logic avail,
    input logic err,
    input logic done,
    input logic dev_ack,
    input logic wr_ctrl,
    input logic rd_din
);
    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= 0;
        else              busy_cnt <= busy_cnt + 1;
    end

    p_launch_needs_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd));

    p_ack_finishes_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && dev_ack) |=> (!busy && !cmd && !err && done));

    p_read_latches_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && dev_ack && !wnr) |=> avail);

    p_pop_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_din && !(busy && dev_ack)) |=> !avail);

    p_window_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < TIMEOUT));

    p_abort_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !dev_ack && busy_cnt == TIMEOUT - 1) |=> (!busy && !cmd && err && done));

    p_clean_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!err && !done));

    p_locked_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd && wr_ctrl) |=> ($stable(wnr) && $stable(mode)));
endmodule

bind polled_port_ctrl pp_checker #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .cmd     (regs_q.cmd),
    .wnr     (regs_q.wnr),
    .mode    (regs_q.mode),
    .avail   (regs_q.avail),
    .err     (regs_q.err),
    .done    (regs_q.done),
    .dev_ack (dev_ack),
    .wr_ctrl (wr_ctrl),
    .rd_din  (rd_din)
);

// File: tb/polled_port_ctrl_test.sv
module polled_port_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       dev_req, dev_we, dev_mode;
    logic [7:0] dev_wdata;
    logic       dev_ack = 1'b0;
    logic [7:0] dev_rdata = '0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    polled_port_ctrl #(.TIMEOUT(TMO)) uut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_req(dev_req), .dev_we(dev_we), .dev_wdata(dev_wdata),
        .dev_mode(dev_mode), .dev_ack(dev_ack), .dev_rdata(dev_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                tests++;
                $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] din_model;
        logic       avail_model;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;

        // R1 / R2: reset state and unmapped offsets
        check("R1 dev_req", dev_req, 0);
        for (int a = 0; a < 16; a++) begin
            peek(4'(a), v);
            check("R1 R2 reset readback", v, 0);
        end

        // R2: outgoing register read/write, read-only registers ignore writes
        bus_write(4'h4, 8'hA5);
        peek(4'h4, v); check("R2 dout readback", v, 8'hA5);
        bus_write(4'h0, 8'hFF);
        peek(4'h0, v); check("R2 din read-only", v, 0);
        bus_write(4'h8, 8'hFF);
        peek(4'h8, v); check("R2 status read-only", v, 0);
        bus_write(4'h4, 8'h5A);
        peek(4'h4, v); check("R2 dout rewrite", v, 8'h5A);

        // R10: mode bit without a command
        bus_write(4'hC, 8'h04);
        check("R10 dev_mode set", dev_mode, 1);
        peek(4'hC, v); check("R10 ctrl readback", v, 8'h04);
        bus_write(4'hC, 8'h00);
        check("R10 dev_mode clear", dev_mode, 0);

        din_model = 8'h00;
        avail_model = 1'b0;

        for (int wr = 0; wr < 2; wr++) begin
            for (int d = 0; d <= TMO + 1; d++) begin
                logic [7:0] out_b, in_b;
                logic       expect_ok;
                out_b = 8'((d * 37 + wr * 91 + 3) & 8'hFF);
                in_b  = 8'((d * 53 + 17) ^ 8'hC3);
                expect_ok = (d < TMO);

                if (wr == 1) bus_write(4'h4, out_b);
                bus_write(4'hC, 8'(1 | (wr << 1) | ((d & 1) << 2)));
                // R3: pending, not yet busy; flags cleared at command
                peek(4'h8, v);
                check("R3 status right after command", v & 8'h0D, 0);
                peek(4'hC, v);
                check("R3 ctrl readback", v, 1 | (wr << 1) | ((d & 1) << 2));
                check("R10 dev_mode follows", dev_mode, d & 1);
                @(negedge clk);
                check("R3 dev_req one edge later", dev_req, 1);
                check("R3 dev_we", dev_we, wr);
                if (wr == 1) check("R3 dev_wdata", dev_wdata, out_b);

                // R9: writes while pending are ignored
                if (d == 2) begin
                    bus_write(4'hC, 8'h00 | ((wr ^ 1) << 1));
                    bus_write(4'h4, 8'hEE);
                    peek(4'hC, v);
                    check("R9 ctrl locked", v, 1 | (wr << 1) | ((d & 1) << 2));
                    peek(4'h4, v);
                    check("R9 dout locked", v, (wr == 1) ? out_b : dev_wdata);
                    for (int j = 2; j < d; j++) @(negedge clk);
                end else begin
                    for (int j = 0; j < d; j++) @(negedge clk);
                end

                dev_ack = 1'b1; dev_rdata = in_b;
                @(negedge clk);
                dev_ack = 1'b0; dev_rdata = 8'h00;

                if (expect_ok && wr == 0) begin
                    din_model = in_b;
                    avail_model = 1'b1;
                end
                peek(4'h8, v);
                if (expect_ok) begin
                    check("R4 status after ack", v, 8'h08 | (avail_model << 1));
                end else begin
                    check("R7 status after abort", v, 8'h0C | (avail_model << 1));
                end
                check("R4 R7 dev_req low", dev_req, 0);
                peek(4'hC, v);
                check("R4 R7 cmd cleared", v & 1, 0);
                if (wr == 1) begin
                    bus_read(4'h0, v);
                    check("R6 din untouched by output", v, din_model);
                    avail_model = 1'b0;
                end else begin
                    bus_read(4'h0, v);
                    check(expect_ok ? "R5 din latched" : "R7 no latch on abort", v, din_model);
                    avail_model = 1'b0;
                    peek(4'h8, v);
                    check("R5 avail cleared by read", (v >> 1) & 1, 0);
                end
                if (!expect_ok) begin
                    // R8: error persists through status reads
                    for (int k = 0; k < 3; k++) bus_read(4'h8, v);
                    check("R8 error persists", (v >> 2) & 1, 1);
                end
            end
        end

        // R8: error cleared by next command
        bus_write(4'hC, 8'h01);
        peek(4'h8, v);
        check("R8 error cleared on new command", (v >> 2) & 1, 0);
        @(negedge clk);
        dev_ack = 1'b1; dev_rdata = 8'h77;
        @(negedge clk);
        dev_ack = 1'b0;
        peek(4'h8, v);
        check("R5 avail after final read", v, 8'h0A);

        // R1: reset in the middle of a command
        bus_write(4'hC, 8'h07);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 dev_req after reset", dev_req, 0);
        for (int a = 0; a < 16; a += 4) begin
            peek(4'(a), v);
            check("R1 regs after reset", v, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule